// File: doc/BRIEF.md
# Layer Completion Handshake for Dual-Output Neuron Networks

This block sequences a feed-forward network of binary neurons whose evaluation time depends on analog delays rather than on a fixed schedule. Each neuron drives two outputs, one excitatory and one inhibitory. A neuron has decided once either output goes high. The controller never waits for a timer. It watches the neurons' own outputs and lets each layer start as soon as the layer in front of it has fully decided.

A new-input strobe raises a one-cycle precharge pulse that returns every neuron to its undecided state. The same strobe clears all progress. When the pulse ends, the first layer is enabled. A layer is complete once every one of its neurons shows a high output. That completion enables the next layer, and completion of the final layer marks the network result as ready. If a neuron in an enabled layer shows both outputs high at once, the layer's clash flag is raised. This models an arbiter fault.

The layer count and the per-layer neuron count are parameters. Neuron `n` of layer `k` sits at bit `k*NPL+n` of both output-pair buses.

Top module: `layer_handshake`

## Requirements
- R1: While `rst_n` is low, `precharge`, `layer_eval`, `layer_done`, `layer_err` and `net_done` are all 0.
- R2: A clock edge that samples `new_in` high sets `precharge` to 1 and clears every bit of `layer_eval`, `layer_done` and `layer_err`.
- R3: `precharge` falls at the first edge that samples `new_in` low, and `layer_eval[0]` rises at that same edge. While `new_in` stays high, `layer_eval[0]` stays 0.
- R4: A neuron is finished when its excitatory or its inhibitory bit is 1. `layer_done[k]` rises at the first edge at which `layer_eval[k]` is 1 and every neuron of layer k is finished.
- R5: Once set, `layer_done`, `layer_err` and `layer_eval` bits stay set until the next `new_in`, even if the neuron outputs return to 0.
- R6: `layer_eval[k+1]` rises at the edge after `layer_done[k]` rises.
- R7: Neuron outputs of a layer whose `layer_eval` bit is 0 have no effect on that layer's done or clash flag.
- R8: `layer_err[k]` rises at the first edge at which `layer_eval[k]` is 1 and any neuron of layer k has both bits at 1.
- R9: `net_done` equals `layer_done[LAYERS-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| new_in | input | 1 | New input has arrived; restarts the network |
| neu_exc | input | LAYERS*NPL | Excitatory output of every neuron |
| neu_inh | input | LAYERS*NPL | Inhibitory output of every neuron |
| precharge | output | 1 | Global precharge pulse to all neurons |
| layer_eval | output | LAYERS | Per-layer evaluate enable |
| layer_done | output | LAYERS | Per-layer completion flag |
| layer_err | output | LAYERS | Per-layer both-outputs-high flag |
| net_done | output | 1 | Final layer complete; result ready |

## Verification
A wrong internal state shows up at the ports within one edge. A completion register that sets too early would raise `layer_done` while some neuron is still undecided. It would then raise the next layer's enable one edge later. The bench sweeps every excitatory/inhibitory combination of the first layer and compares the done and clash flags against the OR/AND and AND/OR reductions it computes itself. It also follows each completing pattern down the enable chain to `net_done`, so an off-by-one in the chain is caught at the exact edge. It checks that flags persist after the outputs drop and that an idle layer ignores outputs that are already decided.

// File: rtl/layer_handshake.sv
module layer_handshake #(
  parameter int LAYERS = 3,
  parameter int NPL    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  new_in,
  input  logic [LAYERS*NPL-1:0] neu_exc,
  input  logic [LAYERS*NPL-1:0] neu_inh,
  output logic                  precharge,
  output logic [LAYERS-1:0]     layer_eval,
  output logic [LAYERS-1:0]     layer_done,
  output logic [LAYERS-1:0]     layer_err,
  output logic                  net_done
);
  localparam int NTOT = LAYERS * NPL;

  logic [NTOT-1:0]   decided;
  logic [NTOT-1:0]   both_hi;
  logic [LAYERS-1:0] all_fin;
  logic [LAYERS-1:0] clash;
  logic [LAYERS:0]   start_chain;

  assign decided = neu_exc | neu_inh;
  assign both_hi = neu_exc & neu_inh;

  for (genvar k = 0; k < LAYERS; k++) begin : g_layer
    assign all_fin[k] = &decided[k*NPL +: NPL];
    assign clash[k]   = |both_hi[k*NPL +: NPL];
  end

  // layer 0 starts after precharge; layer k+1 after layer k completes
  assign start_chain = {layer_done, precharge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      precharge  <= 1'b0;
      layer_eval <= '0;
      layer_done <= '0;
      layer_err  <= '0;
    end else if (new_in) begin
      precharge  <= 1'b1;
      layer_eval <= '0;
      layer_done <= '0;
      layer_err  <= '0;
    end else begin
      precharge  <= 1'b0;
      layer_eval <= layer_eval | start_chain[LAYERS-1:0];
      layer_done <= layer_done | (layer_eval & all_fin);
      layer_err  <= layer_err  | (layer_eval & clash);
    end
  end

  assign net_done = layer_done[LAYERS-1];
endmodule

module layer_handshake_chk #(
  parameter int LAYERS = 3,
  parameter int NPL    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              new_in,
  input logic              precharge,
  input logic [LAYERS-1:0] layer_eval,
  input logic [LAYERS-1:0] layer_done,
  input logic [LAYERS-1:0] layer_err,
  input logic              net_done
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (!precharge && layer_eval == '0 && layer_done == '0 && !net_done)); // R1
  AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) new_in |=> (precharge && layer_eval == '0 && layer_done == '0 && layer_err == '0)); // R2
  AST_PRECHARGE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (precharge && !new_in) |=> (!precharge && layer_eval[0])); // R3
  AST_DONE_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rst_n) (layer_done & ~layer_eval) == '0); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !new_in |=> ((layer_done & $past(layer_done)) == $past(layer_done) && (layer_err & $past(layer_err)) == $past(layer_err))); // R5
  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!new_in && layer_done[0]) |=> layer_eval[LAYERS > 1 ? 1 : 0]); // R6
  AST_NET_READY: assert property (@(posedge clk) disable iff (!rst_n) $rose(net_done) |-> $past(layer_eval[LAYERS-1])); // R9
endmodule

bind layer_handshake layer_handshake_chk #(.LAYERS(LAYERS), .NPL(NPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .new_in(new_in), .precharge(precharge),
  .layer_eval(layer_eval), .layer_done(layer_done), .layer_err(layer_err),
  .net_done(net_done)
);

// File: tb/layer_handshake_bench.sv
module layer_handshake_bench;
  localparam int L = 3;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic new_in = 1'b0;
  logic [L*N-1:0] neu_exc = '0;
  logic [L*N-1:0] neu_inh = '0;
  logic precharge, net_done;
  logic [L-1:0] layer_eval, layer_done, layer_err;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  layer_handshake #(.LAYERS(L), .NPL(N)) u_layer_handshake (
    .clk(clk), .rst_n(rst_n), .new_in(new_in), .neu_exc(neu_exc), .neu_inh(neu_inh),
    .precharge(precharge), .layer_eval(layer_eval), .layer_done(layer_done),
    .layer_err(layer_err), .net_done(net_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic restart();
    new_in = 1'b1;
    step();
    chk("R2 precharge", precharge, 1);
    chk("R2 cleared", {layer_eval, layer_done, layer_err}, 0);
    new_in = 1'b0;
    step();
    chk("R3 precharge falls", precharge, 0);
    chk("R3 eval0", layer_eval, 3'b001);
  endtask

  initial begin
    #5;
    chk("R1 reset", {precharge, layer_eval, layer_done, layer_err, net_done}, 0);
    step();
    chk("R1 reset held", {precharge, layer_eval, layer_done, layer_err, net_done}, 0);
    rst_n = 1'b1;
    step();

    // hold new_in: layer 0 must not start
    new_in = 1'b1;
    step();
    step();
    chk("R3 held strobe", {precharge, layer_eval}, 4'b1000);

    // sweep: per neuron code bit0=exc bit1=inh over all 64 patterns
    for (int p = 0; p < 64; p++) begin
      bit fin, bad;
      logic [N-1:0] e, h;
      for (int n = 0; n < N; n++) begin
        e[n] = ((p >> (2*n)) & 1) != 0;
        h[n] = ((p >> (2*n+1)) & 1) != 0;
      end
      fin = &(e | h);
      bad = |(e & h);
      neu_exc = '0;
      neu_inh = '0;
      restart();
      neu_exc = {{(L-1)*N{1'b1}}, e};
      neu_inh = {{(L-1)*N{1'b0}}, h};
      step();
      chk("R4 layer0 done", layer_done, {2'b00, fin});
      chk("R8 layer0 clash", layer_err, {2'b00, bad});
      chk("R7 idle layer ignored", layer_done[1], 0);
      step();
      chk("R6 eval1", layer_eval, {1'b0, fin, 1'b1});
      if (fin) begin
        step();
        chk("R4 layer1 done", layer_done, 3'b011);
        step();
        chk("R6 eval2", layer_eval, 3'b111);
        chk("R9 not yet", net_done, 0);
        step();
        chk("R9 net done", {net_done, layer_done}, 4'b1111);
        neu_exc = '0;
        neu_inh = '0;
        step();
        chk("R5 done holds", {net_done, layer_done, layer_eval}, 7'b1111111);
        chk("R5 err holds", layer_err, {2'b00, bad});
      end
    end

    // partial layer stalls, then completes later
    neu_exc = '0;
    neu_inh = '0;
    restart();
    neu_exc = 9'b111_111_011;
    step();
    step();
    chk("R4 stalled", {layer_done, layer_eval}, 6'b000001);
    neu_inh = 9'b000_000_100;
    step();
    chk("R4 late finish", layer_done, 3'b001);
    // new input mid-flight clears everything
    new_in = 1'b1;
    step();
    chk("R2 mid-flight clear", {precharge, layer_eval, layer_done, layer_err}, 10'b1000000000);
    new_in = 1'b0;
    neu_exc = '0;
    neu_inh = '0;
    step();
    chk("R3 restart eval0", layer_eval, 3'b001);

    // clash on layer 1 only counted once it is enabled
    neu_exc = 9'b000_111_111;
    neu_inh = 9'b000_001_000;
    step();
    chk("R7 layer1 clash ignored", layer_err, 0);
    step();
    step();
    chk("R8 layer1 clash", layer_err, 3'b010);

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule